// File: doc/BRIEF.md
# Line Sensor Command Decoder and Register File

This block sits between a byte-level serial receiver and the rest of a linear image sensor's control logic. Every received byte arrives as a single-cycle `rxValid` pulse. The block interprets each byte against a small command set and emits single-cycle action strobes to the pixel readout sequencer. The actions are main reset, start integration, sample, read pixels and abort. Two compound opcodes expand into ordered runs of these strobes on consecutive cycles.

The block also holds the per-zone configuration: a signed-magnitude dark-level offset and a 5-bit gain for each of three zones, plus a mode byte whose bit 4 puts the analog side to sleep. Software writes a register with a two-byte sequence, where the low five bits of the first byte select the address. It reads a register with a one-byte command. The read answer leaves as a one-cycle byte request to the shared serial transmitter, a fixed number of clocks after the command. The transmitter adds the start and stop framing and sends the byte LSB first.

The byte interpreter can be forced back to expecting a command in two ways: a pulse on the interface-reset input, or three main-reset bytes in a row. The configuration storage has no reset, so its contents survive both the block reset and the main-reset command.

Top module: `line_sensor_cmd`

## Requirements
- R1: An accepted command byte 0x1B, 0x08, 0x10, 0x02 or 0x19 raises exactly one strobe in the cycle after the accepting edge. The strobes are, in that order, main reset, start integration, sample, read pixels and abort.
- R2: Opcode 0x12 raises the sample strobe in the cycle after the accepting edge and the read-pixels strobe in the next cycle.
- R3: Opcode 0x16 raises sample, read pixels and start integration on three consecutive cycles, beginning in the cycle after the accepting edge.
- R4: A byte 0x40–0x5F sets the write address to its bits 4:0. The next received byte is stored at that address, and the zone outputs show the new value in the cycle after the data byte's accepting edge.
- R5: A byte 0x60–0x7F requests a read of address bits 4:0. `txReq` is high for exactly one cycle, four clocks after the accepting edge, and carries the register contents on `txByte`.
- R6: The address map is as follows. Offsets of zones 0, 1 and 2 are at 0x00, 0x02 and 0x04 (8 bits each). Gains of the same zones are at 0x01, 0x03 and 0x05 (5 bits each). The mode byte is at 0x1F, and `sleepMode` follows mode bit 4. In `zoneOffset` and `zoneGain`, zone z occupies slice z (zone 0 in the low bits).
- R7: Gain registers keep only data bits 4:0 and read back with bits 7:5 as zero.
- R8: Writes to any address outside the map change no register. Reads of such an address return 0x00.
- R9: Any other command byte (below 0x40 and not listed in R1–R3, or 0x80 and above) raises no strobe and no transmit. The next byte is again treated as a command.
- R10: An `ifReset` pulse drops a pending register write. The next byte is decoded as a command and the register is not written.
- R11: Three consecutive 0x1B bytes leave the interpreter expecting a command, even when the first of them arrives as write data.
- R12: Register contents are not changed by `rstN` or by the main-reset command.
- R13: While and after `rstN` is asserted, all strobes and `txReq` are low until a command arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset of the interpreter state |
| rxValid | input | 1 | One-cycle pulse: a received byte is on rxByte |
| rxByte | input | 8 | Received byte |
| ifReset | input | 1 | One-cycle interface-reset pulse from the receiver |
| actMainRst | output | 1 | Main reset strobe |
| actStartInt | output | 1 | Start integration strobe |
| actSample | output | 1 | Sample strobe |
| actReadPix | output | 1 | Read pixels strobe |
| actAbort | output | 1 | Abort readout strobe |
| txReq | output | 1 | One-cycle byte transmit request |
| txByte | output | 8 | Byte to transmit, valid with txReq |
| zoneOffset | output | 24 | Per-zone sign-magnitude offsets (bit 7 of each set means negative) |
| zoneGain | output | 15 | Per-zone 5-bit gains |
| sleepMode | output | 1 | Mode register bit 4 |

## Verification
A wrong interpreter state shows as a misread byte. Write data is taken for an opcode, which fires a strobe or transmit nobody asked for, or an opcode is swallowed as data, which silently changes a zone output. The scoreboard catches either one at the cycle where the first unexpected or missing strobe was due. A wrong read address or delay counter shows four clocks after the read command, as a transmit request in the wrong cycle or with the wrong byte. Corruption of stored configuration that no strobe reveals appears on the zone outputs and is compared directly after each phase.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;

  // command opcodes
  localparam logic [7:0] OP_MAIN_RST   = 8'h1B;
  localparam logic [7:0] OP_START      = 8'h08;
  localparam logic [7:0] OP_SAMPLE     = 8'h10;
  localparam logic [7:0] OP_READPIX    = 8'h02;
  localparam logic [7:0] OP_ABORT      = 8'h19;
  localparam logic [7:0] OP_SMP_READ   = 8'h12;
  localparam logic [7:0] OP_SMP_RD_ST  = 8'h16;

  // register command groups in bits 7:5
  localparam logic [2:0] GRP_WRITE = 3'b010;
  localparam logic [2:0] GRP_READ  = 3'b011;

  localparam logic [ADDR_W-1:0] MODE_ADDR = 5'h1F;
  localparam int SLEEP_BIT = 4;

  typedef struct packed {
    logic mainRst;
    logic startInt;
    logic sample;
    logic readPix;
    logic abort;
  } action_t;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic              rdFire;
    logic [ADDR_W-1:0] rdAddr;
  } regCtl_t;
endpackage

// File: rtl/lsc_ctrl.sv
module lsc_ctrl
  import lsc_pkg::*;
#(
  parameter int RD_DELAY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              ifReset,
  output action_t           act,
  output regCtl_t           regCtl
);
  localparam int CNT_W = $clog2(RD_DELAY + 1);

  typedef enum logic {ST_CMD, ST_DATA} state_t;

  state_t            state;
  logic [ADDR_W-1:0] wrAddrQ;
  logic [ADDR_W-1:0] rdAddrQ;
  logic              pendRead;
  logic              pendStart;
  logic [CNT_W-1:0]  rdCnt;
  logic              acceptCmd;

  assign acceptCmd = rxValid && (state == ST_CMD) && !ifReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_CMD;
      act       <= '0;
      wrAddrQ   <= '0;
      rdAddrQ   <= '0;
      pendRead  <= 1'b0;
      pendStart <= 1'b0;
      rdCnt     <= '0;
    end else begin
      act <= '0;
      if (rdCnt != '0) rdCnt <= rdCnt - 1'b1;
      if (ifReset) begin
        state     <= ST_CMD;
        pendRead  <= 1'b0;
        pendStart <= 1'b0;
        rdCnt     <= '0;
      end else begin
        // drain the expansion of a compound opcode, one strobe per cycle
        if (pendRead) begin
          act.readPix <= 1'b1;
          pendRead    <= 1'b0;
        end else if (pendStart) begin
          act.startInt <= 1'b1;
          pendStart    <= 1'b0;
        end
        if (rxValid) begin
          if (state == ST_DATA) begin
            state <= ST_CMD;
          end else if (rxByte[7:5] == GRP_WRITE) begin
            wrAddrQ <= rxByte[ADDR_W-1:0];
            state   <= ST_DATA;
          end else if (rxByte[7:5] == GRP_READ) begin
            rdAddrQ <= rxByte[ADDR_W-1:0];
            rdCnt   <= CNT_W'(RD_DELAY);
          end else begin
            case (rxByte)
              OP_MAIN_RST:  act.mainRst  <= 1'b1;
              OP_START:     act.startInt <= 1'b1;
              OP_SAMPLE:    act.sample   <= 1'b1;
              OP_READPIX:   act.readPix  <= 1'b1;
              OP_ABORT:     act.abort    <= 1'b1;
              OP_SMP_READ: begin
                act.sample <= 1'b1;
                pendRead   <= 1'b1;
              end
              OP_SMP_RD_ST: begin
                act.sample <= 1'b1;
                pendRead   <= 1'b1;
                pendStart  <= 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  always_comb begin
    regCtl        = '0;
    regCtl.wrEn   = rxValid && (state == ST_DATA) && !ifReset;
    regCtl.wrAddr = wrAddrQ;
    regCtl.wrData = rxByte;
    regCtl.rdFire = (rdCnt == CNT_W'(1));
    regCtl.rdAddr = rdAddrQ;
  end

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({act.mainRst, act.startInt, act.sample, act.readPix, act.abort}));

  // R2
  smp_first_chk: assert property (@(posedge clk) disable iff (!rstN || ifReset)
    (acceptCmd && (rxByte == OP_SMP_READ || rxByte == OP_SMP_RD_ST)) |=> act.sample);

  // R2
  smp_then_read_chk: assert property (@(posedge clk) disable iff (!rstN || ifReset)
    (act.sample && pendRead) |=> act.readPix);

  // R3
  read_then_start_chk: assert property (@(posedge clk) disable iff (!rstN || ifReset)
    (act.readPix && pendStart) |=> act.startInt);

  // R10
  ifreset_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ifReset |=> !regCtl.wrEn);
endmodule

// File: rtl/lsc_regs.sv
module lsc_regs
  import lsc_pkg::*;
#(
  parameter int NUM_ZONES = 3,
  parameter int OFS_W     = 8,
  parameter int GAIN_W    = 5
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  regCtl_t                     regCtl,
  output logic [NUM_ZONES*OFS_W-1:0]  zoneOffset,
  output logic [NUM_ZONES*GAIN_W-1:0] zoneGain,
  output logic                        sleepMode,
  output logic                        txReq,
  output logic [DATA_W-1:0]           txByte
);
  localparam int MAP_TOP = 2 * NUM_ZONES;

  logic [OFS_W-1:0]  ofsQ  [NUM_ZONES];
  logic [GAIN_W-1:0] gainQ [NUM_ZONES];
  logic [DATA_W-1:0] modeQ;
  logic [DATA_W-1:0] rdData;
  logic              wrKnown;

  // configuration storage: deliberately without reset
  always_ff @(posedge clk) begin
    for (int z = 0; z < NUM_ZONES; z++) begin
      if (regCtl.wrEn && regCtl.wrAddr == ADDR_W'(2 * z))
        ofsQ[z] <= regCtl.wrData[OFS_W-1:0];
      if (regCtl.wrEn && regCtl.wrAddr == ADDR_W'(2 * z + 1))
        gainQ[z] <= regCtl.wrData[GAIN_W-1:0];
    end
    if (regCtl.wrEn && regCtl.wrAddr == MODE_ADDR)
      modeQ <= regCtl.wrData;
  end

  always_comb begin
    rdData = '0;
    for (int z = 0; z < NUM_ZONES; z++) begin
      if (regCtl.rdAddr == ADDR_W'(2 * z))     rdData = DATA_W'(ofsQ[z]);
      if (regCtl.rdAddr == ADDR_W'(2 * z + 1)) rdData = DATA_W'(gainQ[z]);
    end
    if (regCtl.rdAddr == MODE_ADDR) rdData = modeQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReq  <= 1'b0;
      txByte <= '0;
    end else begin
      txReq <= regCtl.rdFire;
      if (regCtl.rdFire) txByte <= rdData;
    end
  end

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zoneOut
    assign zoneOffset[z*OFS_W +: OFS_W]  = ofsQ[z];
    assign zoneGain[z*GAIN_W +: GAIN_W]  = gainQ[z];
  end
  assign sleepMode = modeQ[SLEEP_BIT];

  assign wrKnown = (32'(regCtl.wrAddr) < MAP_TOP) || (regCtl.wrAddr == MODE_ADDR);

  // R5
  tx_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReq |=> !txReq);

  // R4
  gain0_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regCtl.wrEn && regCtl.wrAddr == ADDR_W'(1))
      |=> zoneGain[GAIN_W-1:0] == $past(regCtl.wrData[GAIN_W-1:0]));

  // R8
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regCtl.wrEn && !wrKnown) |=> ($stable(zoneOffset) && $stable(zoneGain)));
endmodule

// File: rtl/line_sensor_cmd.sv
module line_sensor_cmd
  import lsc_pkg::*;
#(
  parameter int NUM_ZONES = 3,
  parameter int OFS_W     = 8,
  parameter int GAIN_W    = 5,
  parameter int RD_DELAY  = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rxValid,
  input  logic [7:0]                  rxByte,
  input  logic                        ifReset,
  output logic                        actMainRst,
  output logic                        actStartInt,
  output logic                        actSample,
  output logic                        actReadPix,
  output logic                        actAbort,
  output logic                        txReq,
  output logic [7:0]                  txByte,
  output logic [NUM_ZONES*OFS_W-1:0]  zoneOffset,
  output logic [NUM_ZONES*GAIN_W-1:0] zoneGain,
  output logic                        sleepMode
);
  action_t act;
  regCtl_t regCtl;

  lsc_ctrl #(.RD_DELAY(RD_DELAY)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .rxValid (rxValid),
    .rxByte  (rxByte),
    .ifReset (ifReset),
    .act     (act),
    .regCtl  (regCtl)
  );

  lsc_regs #(.NUM_ZONES(NUM_ZONES), .OFS_W(OFS_W), .GAIN_W(GAIN_W)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .regCtl     (regCtl),
    .zoneOffset (zoneOffset),
    .zoneGain   (zoneGain),
    .sleepMode  (sleepMode),
    .txReq      (txReq),
    .txByte     (txByte)
  );

  assign actMainRst  = act.mainRst;
  assign actStartInt = act.startInt;
  assign actSample   = act.sample;
  assign actReadPix  = act.readPix;
  assign actAbort    = act.abort;
endmodule

// File: tb/line_sensor_cmd_tb.sv
`timescale 1ns/1ps
module line_sensor_cmd_tb;
  localparam int K_RST = 0, K_START = 1, K_SMP = 2, K_READ = 3, K_ABORT = 4, K_TX = 5;
  localparam int GAP = 10;

  logic clk = 1'b0, rstN = 1'b0, rxValid = 1'b0, ifReset = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic actMainRst, actStartInt, actSample, actReadPix, actAbort, txReq;
  logic [7:0] txByte;
  logic [23:0] zoneOffset;
  logic [14:0] zoneGain;
  logic sleepMode;

  line_sensor_cmd u_dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte), .ifReset(ifReset),
    .actMainRst(actMainRst), .actStartInt(actStartInt), .actSample(actSample),
    .actReadPix(actReadPix), .actAbort(actAbort), .txReq(txReq), .txByte(txByte),
    .zoneOffset(zoneOffset), .zoneGain(zoneGain), .sleepMode(sleepMode)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int         kind;
    logic [7:0] data;
    int         at;
    string      req;
  } evt_t;
  evt_t q[$];

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
    nChecks++;
    if (actual !== expected) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, actual, expected);
    end
  endtask

  task automatic popCheck(input int kind, input logic [7:0] d);
    evt_t e;
    nChecks++;
    if (q.size() == 0) begin
      nFails++;
      $display("FAIL R9: unexpected event kind %0d at cycle %0d, expected none", kind, cyc);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.at != cyc || (kind == K_TX && d !== e.data)) begin
        nFails++;
        $display("FAIL %s: got kind %0d cycle %0d data %02h, expected kind %0d cycle %0d data %02h",
                 e.req, kind, cyc, d, e.kind, e.at, e.data);
      end
    end
  endtask

  // monitor: compare design events against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (actMainRst)  popCheck(K_RST, 8'h00);
      if (actStartInt) popCheck(K_START, 8'h00);
      if (actSample)   popCheck(K_SMP, 8'h00);
      if (actReadPix)  popCheck(K_READ, 8'h00);
      if (actAbort)    popCheck(K_ABORT, 8'h00);
      if (txReq)       popCheck(K_TX, txByte);
    end
  end

  task automatic push(input int kind, input logic [7:0] d, input int at, input string req);
    evt_t e;
    e.kind = kind; e.data = d; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  task automatic drive(input logic [7:0] b, output int k);
    @(negedge clk);
    rxValid = 1'b1;
    rxByte  = b;
    @(posedge clk);
    #1;
    k = cyc;
    rxValid = 1'b0;
  endtask

  task automatic idle();
    repeat (GAP) @(negedge clk);
  endtask

  // up to three strobes on consecutive cycles; -1 means none
  task automatic sendAct(input logic [7:0] b, input int k0, input int k1, input int k2, input string req);
    int k;
    drive(b, k);
    if (k0 >= 0) push(k0, 8'h00, k, req);
    if (k1 >= 0) push(k1, 8'h00, k + 1, req);
    if (k2 >= 0) push(k2, 8'h00, k + 2, req);
    idle();
  endtask

  task automatic sendRaw(input logic [7:0] b);
    int k;
    drive(b, k);
    idle();
  endtask

  task automatic sendWrite(input logic [4:0] a, input logic [7:0] d);
    sendRaw({3'b010, a});
    sendRaw(d);
  endtask

  task automatic sendRead(input logic [4:0] a, input logic [7:0] expected, input string req);
    int k;
    drive({3'b011, a}, k);
    push(K_TX, expected, k + 4, req);
    idle();
  endtask

  task automatic finishRun();
    foreach (q[i]) begin
      nChecks++;
      nFails++;
      $display("FAIL %s: missing event kind %0d due at cycle %0d, expected it to occur", q[i].req, q[i].kind, q[i].at);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    // R13: idle outputs during and after reset
    repeat (4) @(negedge clk);
    chk("R13", {26'd0, actMainRst, actStartInt, actSample, actReadPix, actAbort, txReq}, 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R13", {26'd0, actMainRst, actStartInt, actSample, actReadPix, actAbort, txReq}, 32'd0);

    // R1: primitive opcodes
    sendAct(8'h1B, K_RST,   -1, -1, "R1");
    sendAct(8'h08, K_START, -1, -1, "R1");
    sendAct(8'h10, K_SMP,   -1, -1, "R1");
    sendAct(8'h02, K_READ,  -1, -1, "R1");
    sendAct(8'h19, K_ABORT, -1, -1, "R1");

    // R2, R3: compound opcodes
    sendAct(8'h12, K_SMP, K_READ, -1, "R2");
    sendAct(8'h16, K_SMP, K_READ, K_START, "R3");

    // R4, R6, R7: writes across the map
    sendWrite(5'h00, 8'h85);
    sendWrite(5'h01, 8'h13);
    sendWrite(5'h02, 8'h7F);
    sendWrite(5'h03, 8'hFF);
    sendWrite(5'h04, 8'h01);
    sendWrite(5'h05, 8'h0A);
    sendWrite(5'h1F, 8'h10);
    chk("R4", 32'(zoneOffset), 32'h017F85);
    chk("R6", 32'(zoneGain), {17'd0, 5'h0A, 5'h1F, 5'h13});
    chk("R6", 32'(sleepMode), 32'd1);

    // R5, R6, R7: read back
    sendRead(5'h00, 8'h85, "R5");
    sendRead(5'h01, 8'h13, "R6");
    sendRead(5'h02, 8'h7F, "R6");
    sendRead(5'h03, 8'h1F, "R7");
    sendRead(5'h04, 8'h01, "R6");
    sendRead(5'h05, 8'h0A, "R6");
    sendRead(5'h1F, 8'h10, "R5");

    // R8: unmapped addresses
    sendWrite(5'h07, 8'hAA);
    sendWrite(5'h06, 8'h55);
    sendRead(5'h07, 8'h00, "R8");
    sendRead(5'h06, 8'h00, "R8");
    sendRead(5'h10, 8'h00, "R8");
    chk("R8", 32'(zoneOffset), 32'h017F85);
    chk("R8", 32'(zoneGain), {17'd0, 5'h0A, 5'h1F, 5'h13});

    // R9: unknown opcodes do nothing, next byte is a command
    sendRaw(8'h00);
    sendRaw(8'h20);
    sendRaw(8'h80);
    sendRaw(8'hFF);
    sendRaw(8'h0C);
    sendAct(8'h08, K_START, -1, -1, "R9");
    chk("R9", 32'(zoneGain), {17'd0, 5'h0A, 5'h1F, 5'h13});

    // R10: interface reset drops pending write
    sendRaw(8'h41);
    @(negedge clk); ifReset = 1'b1;
    @(negedge clk); ifReset = 1'b0;
    sendAct(8'h08, K_START, -1, -1, "R10");
    chk("R10", 32'(zoneGain[4:0]), 32'h13);

    // R11: three main-reset bytes resynchronise
    sendRaw(8'h43);
    sendAct(8'h1B, -1, -1, -1, "R11");
    sendAct(8'h1B, K_RST, -1, -1, "R11");
    sendAct(8'h1B, K_RST, -1, -1, "R11");
    sendAct(8'h10, K_SMP, -1, -1, "R11");
    chk("R11", 32'(zoneGain), {17'd0, 5'h0A, 5'h1B, 5'h13});

    // R12: storage survives main reset and rstN
    chk("R12", 32'(zoneOffset), 32'h017F85);
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R13", {31'd0, txReq}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12", 32'(zoneOffset), 32'h017F85);
    sendRead(5'h00, 8'h85, "R12");
    sendRead(5'h1F, 8'h10, "R12");
    sendWrite(5'h1F, 8'h00);
    chk("R6", 32'(sleepMode), 32'd0);

    repeat (5) @(negedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule